// File: doc/BRIEF.md
# Log-depth carry-select adder/subtractor

This block is a purely combinational two's-complement add/subtract unit of parameterisable width. The width must be a power of two. A select input chooses between A+B and A-B. The result appears on the sum output, together with an unsigned carry-out and a signed overflow flag.

The carry logic does not pass a carry through every bit position. It works on blocks that double in size at each level. Every block keeps two candidate results: one for an incoming carry of 0 and one for an incoming carry of 1. Two neighbouring blocks merge with 2:1 multiplexers, and the lower block's two candidate carries drive those multiplexers. The carry-in delay therefore grows as the logarithm of the width.

Subtraction complements B and injects a carry of one at the least significant bit. At the top, that carry-in picks between the two final candidates.

Top module: `addsub_unit`

## Requirements
- R1: With sub_sel=0, sum equals (op_a + op_b) mod 2^WIDTH.
- R2: With sub_sel=0, carry_out equals bit WIDTH of the unsigned (WIDTH+1)-bit sum of op_a and op_b.
- R3: With sub_sel=1, sum equals (op_a - op_b) mod 2^WIDTH.
- R4: With sub_sel=1, carry_out is 1 exactly when op_a >= op_b as unsigned numbers, that is, when no borrow occurs.
- R5: ovf is 1 exactly when the true signed result of op_a ± op_b, with both read as two's-complement, lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R6: ovf stays 0 whenever the two effective operands differ in sign. For an add, the effective operands are op_a and op_b. For a subtract, they are op_a and the complement of op_b.
- R7: A carry that enters at bit 0 and must reach carry_out through every bit position produces the correct sum and carry. Two cases show this: all-ones plus one, and zero minus zero.
- R8: All outputs depend only on the present inputs, and each new input value is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, subtracted when sub_sel=1 |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| sum | output | WIDTH | Result modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit (no-borrow when subtracting) |
| ovf | output | 1 | Signed overflow |

## Verification
The unit holds no state. Sum, carry_out and ovf are therefore due in the same cycle as the operands and the select that produce them, with zero cycles of latency. The bench changes inputs on the falling clock edge and samples outputs one nanosecond later, which is well before the next rising edge. It loads a fresh vector before every sample, so every check sees only that vector's result. The expected values come from plain integer arithmetic on the operands, not from the block's structure.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int unsigned DEF_WIDTH = 16;

    // candidate pair of one block: result for incoming carry 0 and 1
    typedef struct packed {
        logic s_c0;
        logic s_c1;
        logic k_c0;
        logic k_c1;
    } leaf_t;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // one bit position evaluated for both possible incoming carries
    function automatic leaf_t leaf_eval(input logic x, input logic y);
        leaf_t r;
        r.s_c0 = x ^ y;
        r.s_c1 = ~(x ^ y);
        r.k_c0 = x & y;
        r.k_c1 = x | y;
        return r;
    endfunction

endpackage

// File: rtl/addsub_prep.sv
module addsub_prep #(
    parameter int unsigned WIDTH = addsub_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] b_eff,
    output logic             c_in
);
    assign b_eff = sub_sel ? ~b_in : b_in;
    assign c_in  = sub_sel;
endmodule

// File: rtl/cs_tree.sv
module cs_tree #(
    parameter int unsigned WIDTH = addsub_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum_c0,
    output logic [WIDTH-1:0] sum_c1,
    output logic             cout_c0,
    output logic             cout_c1
);
    import addsub_pkg::*;

    localparam int unsigned LEVELS = $clog2(WIDTH);

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int unsigned BS   = 1 << lv;
        localparam int unsigned NBLK = WIDTH >> lv;
        logic [WIDTH-1:0] s0;
        logic [WIDTH-1:0] s1;
        logic [NBLK-1:0]  c0;
        logic [NBLK-1:0]  c1;

        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                leaf_t lf;
                assign lf    = leaf_eval(x[i], y[i]);
                assign s0[i] = lf.s_c0;
                assign s1[i] = lf.s_c1;
                assign c0[i] = lf.k_c0;
                assign c1[i] = lf.k_c1;
            end
        end else begin : g_merge
            localparam int unsigned H = BS / 2;
            for (genvar k = 0; k < NBLK; k++) begin : g_blk
                localparam int unsigned BASE = k * BS;
                logic lo_c0;
                logic lo_c1;
                assign lo_c0 = g_lvl[lv-1].c0[2*k];
                assign lo_c1 = g_lvl[lv-1].c1[2*k];
                // lower half passes through unchanged
                assign s0[BASE +: H] = g_lvl[lv-1].s0[BASE +: H];
                assign s1[BASE +: H] = g_lvl[lv-1].s1[BASE +: H];
                // upper half: pick the candidate named by the lower carry
                assign s0[BASE+H +: H] = lo_c0 ? g_lvl[lv-1].s1[BASE+H +: H]
                                               : g_lvl[lv-1].s0[BASE+H +: H];
                assign s1[BASE+H +: H] = lo_c1 ? g_lvl[lv-1].s1[BASE+H +: H]
                                               : g_lvl[lv-1].s0[BASE+H +: H];
                assign c0[k] = lo_c0 ? g_lvl[lv-1].c1[2*k+1] : g_lvl[lv-1].c0[2*k+1];
                assign c1[k] = lo_c1 ? g_lvl[lv-1].c1[2*k+1] : g_lvl[lv-1].c0[2*k+1];
            end
        end
    end

    assign sum_c0  = g_lvl[LEVELS].s0;
    assign sum_c1  = g_lvl[LEVELS].s1;
    assign cout_c0 = g_lvl[LEVELS].c0[0];
    assign cout_c1 = g_lvl[LEVELS].c1[0];
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect #(
    parameter int unsigned WIDTH = addsub_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b_eff,
    input  logic [WIDTH-1:0] res,
    output logic             ovf
);
    logic same_sign;
    assign same_sign = ~(a[WIDTH-1] ^ b_eff[WIDTH-1]);
    assign ovf       = same_sign & (res[WIDTH-1] ^ a[WIDTH-1]);
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
    parameter int unsigned WIDTH = addsub_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             ovf
);
    import addsub_pkg::*;

    initial begin
        if (!is_pow2(WIDTH)) $error("addsub_unit: WIDTH must be a power of two");
    end

    logic [WIDTH-1:0] b_eff;
    logic             c_in;
    logic [WIDTH-1:0] s_c0, s_c1;
    logic             k_c0, k_c1;

    addsub_prep #(.WIDTH(WIDTH)) u_prep (
        .b_in   (op_b),
        .sub_sel(sub_sel),
        .b_eff  (b_eff),
        .c_in   (c_in)
    );

    cs_tree #(.WIDTH(WIDTH)) u_tree (
        .x      (op_a),
        .y      (b_eff),
        .sum_c0 (s_c0),
        .sum_c1 (s_c1),
        .cout_c0(k_c0),
        .cout_c1(k_c1)
    );

    assign sum       = c_in ? s_c1 : s_c0;
    assign carry_out = c_in ? k_c1 : k_c0;

    ovf_detect #(.WIDTH(WIDTH)) u_ovf (
        .a    (op_a),
        .b_eff(b_eff),
        .res  (sum),
        .ovf  (ovf)
    );
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
    parameter int unsigned WIDTH = addsub_pkg::DEF_WIDTH
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_sel,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic             ovf
);
    logic [WIDTH:0] ua, ub, wide_add;
    logic signed [WIDTH:0] sa, sb, sres;

    always_comb begin
        ua       = {1'b0, op_a};
        ub       = {1'b0, op_b};
        wide_add = ua + ub;
        sa       = {op_a[WIDTH-1], op_a};
        sb       = {op_b[WIDTH-1], op_b};
        sres     = sub_sel ? (sa - sb) : (sa + sb);

        if (!sub_sel) begin
            assert_add_sum_R1: assert (sum == wide_add[WIDTH-1:0]);
            assert_add_carry_R2: assert (carry_out == wide_add[WIDTH]);
            assert_no_ovf_mixed_R6: assert (!(op_a[WIDTH-1] != op_b[WIDTH-1] && ovf));
        end else begin
            assert_sub_sum_R3: assert (sum == (op_a - op_b));
            assert_sub_noborrow_R4: assert (carry_out == (op_a >= op_b));
            assert_no_ovf_sub_R6: assert (!(op_a[WIDTH-1] == op_b[WIDTH-1] && ovf));
        end
        assert_ovf_range_R5: assert (ovf == (sres[WIDTH] != sres[WIDTH-1]));
    end
endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .sub_sel  (sub_sel),
    .sum      (sum),
    .carry_out(carry_out),
    .ovf      (ovf)
);

// File: tb/test_addsub_unit.sv
`timescale 1ns/1ps
module test_addsub_unit;
    localparam int unsigned W = 16;
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [W-1:0] op_a, op_b, sum;
    logic sub_sel, carry_out, ovf;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    addsub_unit #(.WIDTH(W)) i_addsub_unit (
        .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
        .sum(sum), .carry_out(carry_out), .ovf(ovf)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h sub=%0d)",
                     tag, act, exp, op_a, op_b, sub_sel);
        end
    endtask

    // apply one vector at the falling edge, sample 1 ns later (zero latency, R8)
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        longint ua, ub, sa, sb, sr;
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = s;
        #1;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        sr = s ? sa - sb : sa + sb;
        if (!s) begin
            chk("R1 sum", longint'(sum), (ua + ub) & longint'(ALL1));
            chk("R2 carry", longint'(carry_out), ((ua + ub) >> W) & 1);
        end else begin
            chk("R3 diff", longint'(sum), (ua - ub) & longint'(ALL1));
            chk("R4 noborrow", longint'(carry_out), (ua >= ub) ? 1 : 0);
        end
        chk("R5 ovf", longint'(ovf),
            (sr > longint'(MAXP) || sr < -longint'(MAXP) - 1) ? 1 : 0);
    endtask

    task automatic test_zero_R8;
        apply('0, '0, 1'b0);
        chk("R8 zero sum", longint'(sum), 0);
        chk("R8 zero flags", longint'({carry_out, ovf}), 0);
    endtask

    task automatic test_chain_R7;
        apply(ALL1, 1, 1'b0);
        chk("R7 ones+1 sum", longint'(sum), 0);
        chk("R7 ones+1 carry", longint'(carry_out), 1);
        apply('0, '0, 1'b1);
        chk("R7 0-0 sum", longint'(sum), 0);
        chk("R7 0-0 carry", longint'(carry_out), 1);
        apply('0, 1, 1'b1);
        chk("R7 0-1 sum", longint'(sum), longint'(ALL1));
        chk("R7 0-1 carry", longint'(carry_out), 0);
    endtask

    task automatic test_overflow_R5;
        apply(MAXP, 1, 1'b0);
        chk("R5 max+1", longint'(ovf), 1);
        apply(MINN, 1, 1'b1);
        chk("R5 min-1", longint'(ovf), 1);
        apply(MINN, ALL1, 1'b0);
        chk("R5 min+(-1)", longint'(ovf), 1);
        apply('0, MINN, 1'b1);
        chk("R5 0-min", longint'(ovf), 1);
        apply(MINN, MINN, 1'b1);
        chk("R5 min-min", longint'(ovf), 0);
    endtask

    task automatic test_mixed_sign_R6;
        apply(MAXP, MINN, 1'b0);
        chk("R6 add mixed", longint'(ovf), 0);
        apply(ALL1, 1, 1'b0);
        chk("R6 add -1+1", longint'(ovf), 0);
        apply(MAXP, MAXP, 1'b1);
        chk("R6 sub same", longint'(ovf), 0);
        apply(ALL1, MINN, 1'b1);
        chk("R6 sub same neg", longint'(ovf), 0);
    endtask

    task automatic test_corners_R1_R3;
        logic [W-1:0] v [4];
        v[0] = '0; v[1] = ALL1; v[2] = MINN; v[3] = MAXP;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int s = 0; s < 2; s++)
                    apply(v[i], v[j], s[0]);
    endtask

    task automatic test_random_R1_R4;
        for (int i = 0; i < 400; i++)
            apply(W'($urandom), W'($urandom), 1'($urandom));
    endtask

    initial begin
        op_a = '0; op_b = '0; sub_sel = 1'b0;
        test_zero_R8();
        test_chain_R7();
        test_overflow_R5();
        test_mixed_sign_R6();
        test_corners_R1_R3();
        test_random_R1_R4();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule